// File: doc/BRIEF.md
# Link Error Monitor Counter

This block watches a serial link for errors and tells the host when too many have arrived. A down-counter starts from a value the host programs. It loses one for each link error that the error detector reports, but only while the received line state shows a live link, which means Idle or Active. When a counted error brings the count to zero, a sticky flag is set and an active-low interrupt line is asserted.

The host has three ways to reach the block. It can write a threshold value, which also loads the counter at once. It can read the current count, and a read strobe then reloads the counter with its all-ones value. It can acknowledge the interrupt. Two host styles are supported. A polling host uses a large start value and reads the count from time to time. An interrupt-driven host uses a small start value and waits for the interrupt. When errors arrive fast, the counter wraps past zero, so the count a host reads is only approximate. Wrapping does not clear the flag.

The line-state code is 3 bits wide. The values are: 0 quiet, 1 halt, 2 master, 3 idle, 4 active, 5 noise, 6 unknown, 7 no signal. A parameter mask selects which codes let errors be counted. By default that is codes 3 and 4.

Top module: `link_err_monitor`

## Requirements
- R1: After reset the count is all ones (8'hFF), the stored threshold is 8'hFF, the interrupt flag is 0 and `irq_n` is 1.
- R2: A `link_err` pulse while `line_state` is 3 (idle) or 4 (active) lowers the count by exactly one on the next clock edge.
- R3: A `link_err` pulse while `line_state` is any other code (0, 1, 2, 5, 6 or 7) has no effect on the count or on the flag.
- R4: A threshold write stores `thr_wdata` as the threshold and loads it into the count on the next edge. If a counted error occurs in the same cycle, the count becomes the written value minus one.
- R5: A count-read strobe reloads the count with 8'hFF on the next edge. If a counted error occurs in the same cycle, the count becomes 8'hFE. When a threshold write and a read strobe occur together, the write takes effect.
- R6: A counted error that makes the next count equal to zero sets the interrupt flag on the same edge. `irq_n` is always the inverse of the flag.
- R7: A counted error at count zero wraps the count to 8'hFF and leaves the flag as it was.
- R8: The flag stays set until an `irq_ack` pulse clears it on the next edge. If the flag is being set in the same cycle as an acknowledge, the set takes effect.
- R9: `cur_count` shows the counter value at all times, and `thr_value` shows the stored threshold at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_err | input | 1 | One-cycle pulse for each detected link error |
| line_state | input | 3 | Received line-state code (3 = idle, 4 = active) |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold value to write |
| cnt_rd | input | 1 | Count read strobe; reloads the counter to all ones |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| cur_count | output | 8 | Current counter value |
| thr_value | output | 8 | Stored threshold |
| lem_flag | output | 1 | Sticky flag: the count reached zero |
| irq_n | output | 1 | Active-low interrupt, the inverse of `lem_flag` |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a mask that enables counting only for codes 3 and 4. Random runs often write small thresholds, so the count reaches zero, wraps and sets the flag many times within a few thousand cycles. This also covers the high-rate wrap case. Directed steps then hit the same-cycle collisions: read with error, write with error, write with read, and set with acknowledge. They also drive every non-counting line-state code, and a reference model in the bench predicts each edge.

// File: rtl/lem_pkg.sv
package lem_pkg;

   localparam int unsigned LS_W = 3;

   typedef enum logic [LS_W-1:0] {
      LS_QUIET   = 3'd0,
      LS_HALT    = 3'd1,
      LS_MASTER  = 3'd2,
      LS_IDLE    = 3'd3,
      LS_ACTIVE  = 3'd4,
      LS_NOISE   = 3'd5,
      LS_UNKNOWN = 3'd6,
      LS_NOSIG   = 3'd7
   } line_state_e;

   // One bit per line-state code: set bits let errors be counted.
   localparam logic [(1<<LS_W)-1:0] LS_COUNT_MASK =
      (1 << LS_IDLE) | (1 << LS_ACTIVE);

endpackage

// File: rtl/lem_qual.sv
module lem_qual #(
   parameter int unsigned              LS_W  = 3,
   parameter logic [(1<<LS_W)-1:0]     MASK  = '0,
   localparam int unsigned             NCODE = 1 << LS_W
) (
   input  logic            link_err,
   input  logic [LS_W-1:0] line_state,
   output logic            dec_en
);

   if (MASK == '0) begin : g_bad_mask
      $error("lem_qual: MASK enables no line state");
   end

   logic [NCODE-1:0] code_ok;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      if (MASK[c]) begin : g_on
         assign code_ok[c] = (line_state == c[LS_W-1:0]);
      end else begin : g_off
         assign code_ok[c] = 1'b0;
      end
   end

   assign dec_en = link_err & (|code_ok);

endmodule

// File: rtl/lem_thr_reg.sv
module lem_thr_reg #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] thr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     thr_q <= '1;
      else if (wr_en) thr_q <= wr_data;
   end

   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   p_thr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(!wr_en) |-> $stable(thr_q));

endmodule

// File: rtl/lem_counter.sv
module lem_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_en,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             reload_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit_zero
);

   if (CNT_W < 2) begin : g_bad_width
      $error("lem_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] RELOAD = '1;
   localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] base_val;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (load_en)        base_val = load_val;
      else if (reload_en) base_val = RELOAD;
      else                base_val = cnt_q;
      cnt_d    = dec_en ? (base_val - ONE) : base_val;
      hit_zero = dec_en && (cnt_d == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RELOAD;
      else        cnt_q <= cnt_d;
   end

   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(dec_en && !load_en && !reload_en)
      |-> cnt_q == $past(cnt_q) - ONE);

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(!dec_en && !load_en && !reload_en)
      |-> $stable(cnt_q));

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(load_en)
      |-> cnt_q == $past(load_val) - (($past(dec_en)) ? ONE : '0));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(reload_en && !load_en)
      |-> cnt_q == RELOAD - (($past(dec_en)) ? ONE : '0));

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(dec_en && !load_en && !reload_en && cnt_q == '0)
      |-> cnt_q == RELOAD);

endmodule

// File: rtl/lem_irq.sv
module lem_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic ack,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_en) flag_q <= 1'b1;
      else if (ack)    flag_q <= 1'b0;
   end

   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(set_en) |-> flag_q);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(flag_q && !ack) |-> flag_q);

   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_armed && $past(ack && !set_en) |-> !flag_q);

endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
   import lem_pkg::*;
#(
   parameter int unsigned           CNT_W   = 8,
   parameter logic [(1<<LS_W)-1:0]  CNT_MSK = LS_COUNT_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_err,
   input  logic [LS_W-1:0]  line_state,
   input  logic             thr_wr,
   input  logic [CNT_W-1:0] thr_wdata,
   input  logic             cnt_rd,
   input  logic             irq_ack,
   output logic [CNT_W-1:0] cur_count,
   output logic [CNT_W-1:0] thr_value,
   output logic             lem_flag,
   output logic             irq_n
);

   logic dec_en;
   logic hit_zero;

   lem_qual #(.LS_W(LS_W), .MASK(CNT_MSK)) u_qual (
      .link_err   (link_err),
      .line_state (line_state),
      .dec_en     (dec_en)
   );

   lem_thr_reg #(.CNT_W(CNT_W)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (thr_wr),
      .wr_data (thr_wdata),
      .thr_q   (thr_value)
   );

   lem_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_en    (dec_en),
      .load_en   (thr_wr),
      .load_val  (thr_wdata),
      .reload_en (cnt_rd),
      .cnt_q     (cur_count),
      .hit_zero  (hit_zero)
   );

   lem_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (hit_zero),
      .ack    (irq_ack),
      .flag_q (lem_flag)
   );

   assign irq_n = ~lem_flag;

   p_no_count_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_err && !CNT_MSK[line_state] |-> !dec_en);

endmodule

// File: tb/link_err_monitor_bench.sv
module link_err_monitor_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_err = 1'b0;
   logic [2:0] line_state = 3'd0;
   logic       thr_wr = 1'b0;
   logic [7:0] thr_wdata = 8'd0;
   logic       cnt_rd = 1'b0;
   logic       irq_ack = 1'b0;
   logic [7:0] cur_count;
   logic [7:0] thr_value;
   logic       lem_flag;
   logic       irq_n;

   int unsigned errors = 0;
   int unsigned checks = 0;
   bit          done = 1'b0;

   logic [7:0] m_cnt = 8'hFF;
   logic [7:0] m_thr = 8'hFF;
   logic       m_flag = 1'b0;

   always #2 clk = ~clk;

   link_err_monitor u_link_err_monitor (
      .clk(clk), .rst_n(rst_n), .link_err(link_err), .line_state(line_state),
      .thr_wr(thr_wr), .thr_wdata(thr_wdata), .cnt_rd(cnt_rd), .irq_ack(irq_ack),
      .cur_count(cur_count), .thr_value(thr_value), .lem_flag(lem_flag), .irq_n(irq_n)
   );

   function automatic bit counts(input logic [2:0] ls);
      return (ls == 3'd3) || (ls == 3'd4);
   endfunction

   function automatic logic [7:0] next_cnt(input logic [7:0] c, input bit e,
      input logic [2:0] ls, input bit wr, input logic [7:0] wd, input bit rd);
      logic [7:0] b;
      b = wr ? wd : (rd ? 8'hFF : c);
      return (e && counts(ls)) ? b - 8'd1 : b;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, cur_count, m_cnt);
      chk("R9", thr_value, m_thr);
      chk("R6", {7'd0, lem_flag}, {7'd0, m_flag});
      chk("R6", {7'd0, irq_n}, {7'd0, ~m_flag});
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit e, input logic [2:0] ls, input bit wr,
                       input logic [7:0] wd, input bit rd, input bit ack,
                       input string tag);
      logic [7:0] nc;
      bit hit;
      link_err = e; line_state = ls; thr_wr = wr; thr_wdata = wd;
      cnt_rd = rd; irq_ack = ack;
      nc  = next_cnt(m_cnt, e, ls, wr, wd, rd);
      hit = e && counts(ls) && (nc == 8'h00);
      m_cnt  = nc;
      if (wr) m_thr = wd;
      m_flag = hit ? 1'b1 : (ack ? 1'b0 : m_flag);
      @(posedge clk);
      #1;
      check_all(tag);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd51723));
      repeat (3) @(negedge clk);
      // R1: reset values
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R4: write threshold 3, then R2 decrements in idle and active
      step(0, 3'd0, 1, 8'd3, 0, 0, "R4");
      step(1, 3'd3, 0, 8'd0, 0, 0, "R2");
      // R3: every non-counting code is ignored
      for (int c = 0; c < 8; c++)
         if (c != 3 && c != 4) step(1, c[2:0], 0, 8'd0, 0, 0, "R3");
      step(1, 3'd4, 0, 8'd0, 0, 0, "R2");
      // R6: 1 -> 0 sets flag
      step(1, 3'd4, 0, 8'd0, 0, 0, "R6");
      // R7: wrap from zero keeps the flag
      step(1, 3'd3, 0, 8'd0, 0, 0, "R7");
      // R8: flag sticky without ack, then cleared by ack
      step(0, 3'd3, 0, 8'd0, 0, 0, "R8");
      step(0, 3'd3, 0, 8'd0, 0, 1, "R8");
      // R5: read with counted error gives FE; write beats read
      step(1, 3'd4, 0, 8'd0, 1, 0, "R5");
      step(0, 3'd4, 1, 8'd9, 1, 0, "R5");
      // R4: write with counted error gives value minus one; write 1 + err hits zero
      step(1, 3'd3, 1, 8'd20, 0, 0, "R4");
      step(1, 3'd3, 1, 8'd1, 0, 1, "R8");

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         bit e, wr, rd, ack;
         logic [2:0] ls;
         logic [7:0] wd;
         string tg;
         e   = ($urandom % 3) != 0;
         ls  = ($urandom % 2) ? (($urandom % 2) ? 3'd3 : 3'd4) : 3'($urandom);
         wr  = ($urandom % 40) == 0;
         rd  = ($urandom % 60) == 0;
         ack = ($urandom % 25) == 0;
         wd  = 8'($urandom % 12);
         if (wr)                     tg = "R4";
         else if (rd)                tg = "R5";
         else if (e && counts(ls))   tg = (m_cnt == 8'h00) ? "R7" : "R2";
         else                        tg = "R3";
         step(e, ls, wr, wd, rd, ack, tg);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule